// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Selectable Bit-Clock Divide

This block is the sending side of a bus-attached asynchronous serial adapter. A parallel write port places a character into a holding register. When the shift stage is free and the far end is ready to receive, the character moves into a frame shift register. From there it leaves on a single serial line, one bit per bit period: a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. The line rests high between characters.

Bit periods are counted from a one-cycle pulse that marks each rising edge of an external transmit clock; that clock is assumed to be already brought into the system clock domain. A bit lasts 1, 16 or 64 such pulses, selected at runtime. The character length, the parity mode, the stop-bit count and the divide ratio are all captured when a character enters the shift stage. Software may therefore change them while a character is still on the line without disturbing it.

The holding register and the shift register together form a double buffer. A status output reports that the holding register can take another character, and an interrupt request follows that status when it is enabled. An active-low clear-to-send input keeps new characters from starting and masks the status. A character that is already being sent still finishes.

Top module: `ast_tx_top`

## Requirements
- R1: After reset `txd` is 1, `tdre` is 1 while `cts_n` is 0, and `irq` is 0 while `irq_en` is 0.
- R2: A frame is one start bit at 0, then the data bits least significant bit first, then the stop bits at 1; between frames `txd` is 1.
- R3: With `data8`=1 a frame carries 8 data bits. With `data8`=0 it carries only the low 7 bits of the character, and bit 7 of the written value has no effect on the line.
- R4: With `par_en`=1 a parity bit follows the last data bit. With `par_odd`=0 the data bits plus the parity bit hold an even number of ones; with `par_odd`=1 they hold an odd number. With `par_en`=0 no parity bit is sent.
- R5: With `two_stop`=0 one stop bit is sent, and with `two_stop`=1 two are sent.
- R6: Each bit lasts exactly N pulses of `tclk_tick`. `div_sel` 2'b00 gives N=1, 2'b01 gives N=16, and 2'b10 or 2'b11 gives N=64.
- R7: A character may be written while another is being sent. It starts, with its start bit, in the second system clock cycle after the last bit period of the previous frame ends, with no idle bit period in between.
- R8: A write clears `tdre` from the next cycle on. `tdre` sets again in the cycle after the character moves into the shift register. A write into a full holding register replaces its content.
- R9: While `cts_n` is 1, `tdre` is 0 and no new frame starts. A frame already started finishes unchanged. When `cts_n` returns to 0, the waiting character starts.
- R10: `irq` is 1 exactly when `irq_en` is 1 and `tdre` is 1.
- R11: The format and divide inputs are captured when a character enters the shift register. Changes to them during a frame do not alter that frame.
- R12: `txd` changes only at the end of a bit period; while no `tclk_tick` pulse arrives, a bit in progress holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tclk_tick | input | 1 | One-cycle pulse per rising edge of the external transmit clock |
| div_sel | input | 2 | Bit-period divide: 00 = 1, 01 = 16, 10/11 = 64 |
| data8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop | input | 1 | 1 = two stop bits, 0 = one |
| irq_en | input | 1 | Enable the transmit interrupt request |
| cts_n | input | 1 | Clear to send, active low |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Character to send |
| txd | output | 1 | Serial data line, idles high |
| tdre | output | 1 | Holding register empty and transmission allowed |
| irq | output | 1 | Transmit interrupt request |

## Verification
The bench builds the block with its default eight-bit character width, so both the 7-bit and 8-bit lengths are reached along with the full-width parity bit. That gives the longest frame of twelve bits: start, eight data bits, parity and two stop bits. Every divide code is used, including the duplicate code for 64, so whole frames of 16 and 64 pulses per bit are walked and each bit is checked at its middle as well as at its start. The bench also toggles clear-to-send before a frame and in the middle of one, changes the format during a frame, and queues a second character behind a running one. These cases cover the double-buffer hand-over and the capture of the format at the start of each frame.

// File: rtl/ast_pkg.sv
package ast_pkg;

    localparam int MAX_DIV = 64;
    localparam int PRE_W   = $clog2(MAX_DIV);

    typedef enum logic [1:0] {
        DIV_BY1  = 2'b00,
        DIV_BY16 = 2'b01,
        DIV_BY64 = 2'b10,
        DIV_ALT  = 2'b11
    } div_sel_e;

    typedef struct packed {
        logic data8;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } fmt_t;

    function automatic logic [PRE_W-1:0] div_last(input logic [1:0] sel);
        logic [PRE_W-1:0] r;
        case (div_sel_e'(sel))
            DIV_BY1:  r = '0;
            DIV_BY16: r = PRE_W'(15);
            default:  r = PRE_W'(MAX_DIV - 1);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ast_prescale.sv
module ast_prescale
    import ast_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       busy,
    input  logic       tclk_tick,
    input  logic [1:0] div_sel,
    output logic       bit_tick
);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
        logic [PRE_W-1:0] last;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        bit_tick = busy && tclk_tick && (st_q.cnt == st_q.last);
        if (load) begin
            st_d.cnt  = '0;
            st_d.last = div_last(div_sel);
        end else if (busy && tclk_tick) begin
            if (st_q.cnt == st_q.last) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ast_holdreg.sv
module ast_holdreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    output logic [DATA_W-1:0] hold_data,
    output logic              full
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.data = wr_data;
            st_d.full = 1'b1;
        end else if (load) begin
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_data = st_q.data;
    assign full      = st_q.full;

endmodule

// File: rtl/ast_shifter.sv
module ast_shifter
    import ast_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    input  fmt_t              fmt,
    input  logic              bit_tick,
    output logic              busy,
    output logic              txd
);

    localparam int FRAME_W = DATA_W + 4;
    localparam int REM_W   = $clog2(FRAME_W);

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] sh;
        logic [REM_W-1:0]   rem;
    } sh_st_t;

    sh_st_t             st_d, st_q;
    logic [DATA_W-1:0]  dmask;
    logic [FRAME_W-1:0] dext;
    logic [FRAME_W-1:0] frame;
    logic               pbit;
    int                 nd;
    int                 nbits;

    always_comb begin
        dmask = data;
        if (!fmt.data8) begin
            dmask[DATA_W-1] = 1'b0;
        end
        nd    = fmt.data8 ? DATA_W : DATA_W - 1;
        pbit  = (^dmask) ^ fmt.par_odd;
        dext  = FRAME_W'(dmask);
        nbits = 2 + nd + (fmt.par_en ? 1 : 0) + (fmt.two_stop ? 1 : 0);
        for (int i = 0; i < FRAME_W; i++) begin
            if (i == 0) begin
                frame[i] = 1'b0;
            end else if (i <= nd) begin
                frame[i] = dext[i-1];
            end else if (i == nd + 1 && fmt.par_en) begin
                frame[i] = pbit;
            end else begin
                frame[i] = 1'b1;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.busy = 1'b1;
            st_d.sh   = frame;
            st_d.rem  = REM_W'(nbits - 1);
        end else if (st_q.busy && bit_tick) begin
            if (st_q.rem == '0) begin
                st_d.busy = 1'b0;
                st_d.sh   = '1;
            end else begin
                st_d.sh  = {1'b1, st_q.sh[FRAME_W-1:1]};
                st_d.rem = st_q.rem - REM_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy <= 1'b0;
            st_q.sh   <= '1;
            st_q.rem  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign txd  = st_q.sh[0];

endmodule

// File: rtl/ast_tx_top.sv
module ast_tx_top
    import ast_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tclk_tick,
    input  logic [1:0]        div_sel,
    input  logic              data8,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              irq_en,
    input  logic              cts_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              tdre,
    output logic              irq
);

    logic              sh_busy;
    logic              full;
    logic              load;
    logic              bit_tick;
    logic [DATA_W-1:0] hold_q;
    fmt_t              fmt;

    assign fmt  = '{data8: data8, par_en: par_en, par_odd: par_odd, two_stop: two_stop};
    assign load = full && !sh_busy && !cts_n;
    assign tdre = !full && !cts_n;
    assign irq  = irq_en && tdre;

    ast_holdreg #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .load      (load),
        .hold_data (hold_q),
        .full      (full)
    );

    ast_prescale u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .busy      (sh_busy),
        .tclk_tick (tclk_tick),
        .div_sel   (div_sel),
        .bit_tick  (bit_tick)
    );

    ast_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .data     (hold_q),
        .fmt      (fmt),
        .bit_tick (bit_tick),
        .busy     (sh_busy),
        .txd      (txd)
    );

endmodule

// File: rtl/ast_tx_chk.sv
module ast_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tclk_tick,
    input logic irq_en,
    input logic cts_n,
    input logic wr_en,
    input logic txd,
    input logic tdre,
    input logic irq,
    input logic busy,
    input logic bit_tick
);

    AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd); // R2

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd); // R2

    AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !tdre); // R8

    AST_CTS_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_n && !busy) |=> !busy); // R9

    AST_CTS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        cts_n |-> !tdre); // R9

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq); // R10

    AST_HOLD_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tclk_tick) |=> $stable(txd)); // R12

    AST_TICK_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> tclk_tick); // R6

endmodule

bind ast_tx_top ast_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tclk_tick (tclk_tick),
    .irq_en    (irq_en),
    .cts_n     (cts_n),
    .wr_en     (wr_en),
    .txd       (txd),
    .tdre      (tdre),
    .irq       (irq),
    .busy      (sh_busy),
    .bit_tick  (bit_tick)
);

// File: tb/tb_ast_tx_top.sv
`timescale 1ns/1ps
module tb_ast_tx_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tclk_tick = 1'b0;
    logic [1:0] div_sel = 2'b00;
    logic       data8 = 1'b1;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       two_stop = 1'b0;
    logic       irq_en = 1'b0;
    logic       cts_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd, tdre, irq;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ast_tx_top #(.DATA_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .tclk_tick(tclk_tick), .div_sel(div_sel),
        .data8(data8), .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
        .irq_en(irq_en), .cts_n(cts_n), .wr_en(wr_en), .wr_data(wr_data),
        .txd(txd), .tdre(tdre), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk) tclk_tick = 1'b1;
        @(negedge clk) tclk_tick = 1'b0;
    endtask

    task automatic write_char(input logic [7:0] d);
        @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    // Walks one frame bit by bit; expected bits are built from the format arguments.
    task automatic run_frame(input string req, input logic [7:0] d, input bit d8,
                             input bit pen, input bit podd, input bit two,
                             input int divn, input bit first_wait);
        logic [11:0] bits;
        int nd, n;
        logic [7:0] dm;
        bits = '1;
        bits[0] = 1'b0;
        nd = d8 ? 8 : 7;
        dm = d8 ? d : {1'b0, d[6:0]};
        for (int i = 0; i < nd; i++) bits[1+i] = dm[i];
        if (pen) bits[1+nd] = (^dm) ^ podd;
        n = 2 + nd + (pen ? 1 : 0) + (two ? 1 : 0);
        if (first_wait) @(negedge clk);
        for (int b = 0; b < n; b++) begin
            chk({req, " bit start"}, int'(txd), int'(bits[b]));
            if (divn > 1) begin
                repeat (divn/2) pulse_tick();
                chk({req, " bit middle"}, int'(txd), int'(bits[b]));
                repeat (divn - divn/2) pulse_tick();
            end else begin
                pulse_tick();
            end
        end
        chk({req, " idle after frame"}, int'(txd), 1);
    endtask

    task automatic set_fmt(input logic [1:0] ds, input bit d8, input bit pen,
                           input bit podd, input bit two);
        @(negedge clk) begin
            div_sel = ds; data8 = d8; par_en = pen; par_odd = podd; two_stop = two;
        end
    endtask

    task automatic t_reset();
        chk("R1 txd", int'(txd), 1);
        chk("R1 tdre", int'(tdre), 1);
        chk("R1 irq", int'(irq), 0);
        @(negedge clk) irq_en = 1'b1;
        #1 chk("R10 irq enabled while empty", int'(irq), 1);
        @(negedge clk) irq_en = 1'b0;
    endtask

    task automatic t_8n1_div1();
        set_fmt(2'b00, 1, 0, 0, 0);
        write_char(8'hA5);
        run_frame("R2 R6 8N1 div1", 8'hA5, 1, 0, 0, 0, 1, 1);
    endtask

    task automatic t_7e2_div16();
        set_fmt(2'b01, 0, 1, 0, 1);
        write_char(8'hD3);
        run_frame("R3 R4 R5 R6 7E2 div16", 8'hD3, 0, 1, 0, 1, 16, 1);
    endtask

    task automatic t_8o1_div64();
        set_fmt(2'b10, 1, 1, 1, 0);
        write_char(8'h3C);
        run_frame("R4 R6 8O1 div64", 8'h3C, 1, 1, 1, 0, 64, 1);
    endtask

    task automatic t_alt_div();
        set_fmt(2'b11, 0, 0, 0, 0);
        write_char(8'hFF);
        run_frame("R3 R6 code11 div64", 8'hFF, 0, 0, 0, 0, 64, 1);
    endtask

    task automatic t_double_buffer();
        set_fmt(2'b00, 1, 1, 0, 1);
        irq_en = 1'b1;
        write_char(8'h81);
        @(negedge clk);
        chk("R8 tdre sets after move", int'(tdre), 1);
        chk("R10 irq follows tdre", int'(irq), 1);
        chk("R7 first frame started", int'(txd), 0);
        write_char(8'h11);
        chk("R8 tdre clear after write while busy", int'(tdre), 0);
        chk("R10 irq clear with tdre", int'(irq), 0);
        write_char(8'h5E);
        chk("R8 tdre stays clear on overwrite", int'(tdre), 0);
        run_frame("R7 first frame", 8'h81, 1, 1, 0, 1, 1, 0);
        run_frame("R7 R8 second frame replaced", 8'h5E, 1, 1, 0, 1, 1, 1);
        chk("R8 tdre after second move", int'(tdre), 1);
        irq_en = 1'b0;
    endtask

    task automatic t_cts();
        set_fmt(2'b00, 1, 0, 0, 0);
        @(negedge clk) cts_n = 1'b1;
        #1 chk("R9 tdre masked", int'(tdre), 0);
        write_char(8'h66);
        repeat (20) pulse_tick();
        chk("R9 no start while blocked", int'(txd), 1);
        chk("R9 tdre stays low", int'(tdre), 0);
        @(negedge clk) cts_n = 1'b0;
        run_frame("R9 start after release", 8'h66, 1, 0, 0, 0, 1, 1);
        write_char(8'h9A);
        @(negedge clk) cts_n = 1'b1;
        run_frame("R9 frame in flight completes", 8'h9A, 1, 0, 0, 0, 1, 0);
        @(negedge clk) cts_n = 1'b0;
    endtask

    task automatic t_latch();
        set_fmt(2'b01, 1, 0, 0, 0);
        write_char(8'hC7);
        @(negedge clk) begin
            div_sel = 2'b00; data8 = 1'b0; par_en = 1'b1; two_stop = 1'b1;
        end
        run_frame("R11 format captured at start", 8'hC7, 1, 0, 0, 0, 16, 0);
    endtask

    task automatic t_no_tick();
        set_fmt(2'b00, 1, 0, 0, 0);
        write_char(8'h01);
        @(negedge clk);
        repeat (10) @(negedge clk);
        chk("R12 start bit held without ticks", int'(txd), 0);
        pulse_tick();
        repeat (10) @(negedge clk);
        chk("R12 first data bit held", int'(txd), 1);
        pulse_tick();
        chk("R12 advanced only on tick", int'(txd), 0);
        repeat (8) pulse_tick();
        chk("R2 back to idle", int'(txd), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_8n1_div1();
        t_7e2_div16();
        t_8o1_div64();
        t_alt_div();
        t_double_buffer();
        t_cts();
        t_latch();
        t_no_tick();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
            wait (done);
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule